// File: doc/BRIEF.md
# Transmit Queue Status and Interrupt Unit

This block holds the words a bus master writes for a serial transmitter and derives every status flag and interrupt that software needs to drive that transmitter. A sixteen-entry first-in first-out queue takes writes from the bus side. The serializer takes words from the head of the queue with a pop strobe and reports through a busy input while a word is still shifting out. The bit serializer and baud timing live outside this block.

Software polls `ready_o` before each write. It waits for `wr_busy_o` to drop to know that a flush has completed. It reads `ovf_o` to learn that a write was lost. One interrupt line merges four sources, each with its own enable bit:
- a fill threshold against a programmable trigger level,
- the fully drained state,
- the sticky overflow,
- a sticky change detector on the clear-to-send input.

A clear pulse empties the queue and resets the sticky conditions. It does not affect any receive logic.

Top module: `uart_txq_status`

## Requirements
- R1: After reset the queue is empty; `ready_o` is 1 exactly when fewer than DEPTH (16) words are queued.
- R2: Words leave in the order they were written. `rd_valid_o` is 1 while the queue holds a word, and `rd_data_o` shows the oldest word. A pop strobe with `rd_valid_o` high removes that word at the next clock edge.
- R3: A write while the queue is full (judged before any pop in the same cycle) is dropped. `ovf_o` rises at that clock edge and stays high until a clear.
- R4: `wr_busy_o` is 1 while any word is queued or `ser_busy_i` is 1, and 0 only when both are idle.
- R5: The drained source (interrupt bit 1) is pending only when the queue is empty and `ser_busy_i` is 0.
- R6: The threshold source (interrupt bit 0) is pending while the number of queued words is less than or equal to `trig_lvl_i`.
- R7: `cts_i` passes through a two-flop synchronizer. A change in either direction sets the sticky change source (interrupt bit 3) at the third clock edge after the change. The source stays set until a clear.
- R8: `clr_i` empties the queue and clears `ovf_o` and the change source at the next edge. A write in the same cycle is discarded and does not raise `ovf_o`.
- R9: `irq_o` is the OR of the pending sources ANDed with `irq_en_i`. The bit positions are 0 for threshold, 1 for drained, 2 for overflow and 3 for the clear-to-send change.
- R10: A pop strobe while the queue is empty has no effect on the queue contents or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | DW (8) | Word to queue |
| pop_i | input | 1 | Serializer takes the head word |
| ser_busy_i | input | 1 | Serializer is still shifting a word |
| cts_i | input | 1 | Asynchronous clear-to-send input |
| trig_lvl_i | input | CW (5) | Threshold trigger level |
| irq_en_i | input | NSRC (4) | Per-source interrupt enables |
| clr_i | input | 1 | Queue clear pulse |
| rd_data_o | output | DW (8) | Oldest queued word |
| rd_valid_o | output | 1 | Queue holds at least one word |
| ready_o | output | 1 | Queue can accept a write |
| wr_busy_o | output | 1 | Data still queued or shifting |
| ovf_o | output | 1 | Sticky overflow status |
| irq_o | output | 1 | Merged transmit interrupt |

## Verification
The checker assumes that `clr_i`, `wr_en_i` and `pop_i` are synchronous pulses sampled at the rising edge. It also assumes that `ser_busy_i` and `irq_en_i` change only between edges. The bench meets these assumptions by driving every input on the falling edge. It also holds `cts_i` at its idle high level through reset, so the synchronizer starts from a known level and sees no false change. The bench changes `cts_i` only while checking R7. Its serializer model holds `ser_busy_i` high over separate windows, so the drained and flush flags can be observed with both an empty queue and an active shifter.

// File: rtl/uart_txq_pkg.sv
`timescale 1ns/1ps
package uart_txq_pkg;
  localparam int unsigned NSRC      = 4;
  localparam int unsigned SRC_THR   = 0;
  localparam int unsigned SRC_EMPTY = 1;
  localparam int unsigned SRC_OVF   = 2;
  localparam int unsigned SRC_CTS   = 3;
endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          lost_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push, pull;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o = (cnt_q == CW'(DEPTH));
  // fullness judged before a same-cycle pop
  assign push   = wr_en_i & ~full_o & ~clr_i;
  assign lost_o = wr_en_i &  full_o & ~clr_i;
  assign pull   = pop_i & (cnt_q != '0) & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= nxt(wptr_q);
      if (pull) rptr_q <= nxt(rptr_q);
      case ({push, pull})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rptr_q];
  assign count_o   = cnt_q;
endmodule

// File: rtl/txq_cts_sync.sv
`timescale 1ns/1ps
module txq_cts_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  output logic chg_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], cts_i};
      prev_q <= sync_q[1];
    end
  end

  assign chg_o = sync_q[1] ^ prev_q;
endmodule

// File: rtl/txq_irq.sv
`timescale 1ns/1ps
module txq_irq
  import uart_txq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            thr_i,
  input  logic            drained_i,
  input  logic            lost_i,
  input  logic            cts_chg_i,
  input  logic [NSRC-1:0] en_i,
  output logic            ovf_o,
  output logic            irq_o
);
  logic            ovf_q, cts_q;
  logic [NSRC-1:0] pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cts_q <= 1'b0;
    end else if (clr_i) begin
      ovf_q <= 1'b0;
      cts_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | lost_i;
      cts_q <= cts_q | cts_chg_i;
    end
  end

  always_comb begin
    pend            = '0;
    pend[SRC_THR]   = thr_i;
    pend[SRC_EMPTY] = drained_i;
    pend[SRC_OVF]   = ovf_q;
    pend[SRC_CTS]   = cts_q;
  end

  assign ovf_o = ovf_q;
  assign irq_o = |(pend & en_i);
endmodule

// File: rtl/uart_txq_status.sv
`timescale 1ns/1ps
module uart_txq_status
  import uart_txq_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            pop_i,
  input  logic            ser_busy_i,
  input  logic            cts_i,
  input  logic [CW-1:0]   trig_lvl_i,
  input  logic [NSRC-1:0] irq_en_i,
  input  logic            clr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_valid_o,
  output logic            ready_o,
  output logic            wr_busy_o,
  output logic            ovf_o,
  output logic            irq_o
);
  logic [CW-1:0] count;
  logic          full, lost, cts_chg;

  txq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i, .wr_en_i, .wr_data_i, .pop_i,
    .rd_data_o, .count_o(count), .full_o(full), .lost_o(lost)
  );

  txq_cts_sync #(.RST_VAL(1'b1)) u_cts (
    .clk_i, .rst_ni, .cts_i, .chg_o(cts_chg)
  );

  txq_irq u_irq (
    .clk_i, .rst_ni, .clr_i,
    .thr_i     (count <= trig_lvl_i),
    .drained_i ((count == '0) && !ser_busy_i),
    .lost_i    (lost),
    .cts_chg_i (cts_chg),
    .en_i      (irq_en_i),
    .ovf_o, .irq_o
  );

  assign rd_valid_o = (count != '0);
  assign ready_o    = ~full;
  assign wr_busy_o  = (count != '0) | ser_busy_i;
endmodule

// File: rtl/txq_chk.sv
`timescale 1ns/1ps
module txq_chk #(
  parameter int unsigned NSRC = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            clr_i,
  input logic            ser_busy_i,
  input logic [NSRC-1:0] irq_en_i,
  input logic            ready_o,
  input logic            rd_valid_o,
  input logic            wr_busy_o,
  input logic            ovf_o,
  input logic            irq_o
);
  // R1
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> ready_o);
  // R3
  lost_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ready_o && !clr_i) |=> ovf_o);
  // R3
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ovf_o && !rd_valid_o && ready_o));
  // R4
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o || ser_busy_i) |-> wr_busy_o);
  // R5
  drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == NSRC'(2)) |-> (irq_o == !wr_busy_o));
  // R9
  masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);
endmodule

bind uart_txq_status txq_chk #(.NSRC(uart_txq_pkg::NSRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .clr_i(clr_i),
  .ser_busy_i(ser_busy_i), .irq_en_i(irq_en_i), .ready_o(ready_o),
  .rd_valid_o(rd_valid_o), .wr_busy_o(wr_busy_o), .ovf_o(ovf_o), .irq_o(irq_o)
);

// File: tb/uart_txq_status_bench.sv
`timescale 1ns/1ps
module uart_txq_status_bench;
  localparam int DW = 8;
  localparam int CW = 5;

  typedef struct packed {
    logic [1:0] op;   // 0 write, 1 pop, 2 idle
    logic [7:0] data;
    logic       valid;
    logic       busy;
    logic [7:0] head;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 8'hA1, 1'b1, 1'b1, 8'hA1},
    '{2'd0, 8'hB2, 1'b1, 1'b1, 8'hA1},
    '{2'd0, 8'hC3, 1'b1, 1'b1, 8'hA1},
    '{2'd1, 8'h00, 1'b1, 1'b1, 8'hB2},
    '{2'd2, 8'h00, 1'b1, 1'b1, 8'hB2},
    '{2'd0, 8'hD4, 1'b1, 1'b1, 8'hB2},
    '{2'd1, 8'h00, 1'b1, 1'b1, 8'hC3},
    '{2'd1, 8'h00, 1'b1, 1'b1, 8'hD4},
    '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00},
    '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00},
    '{2'd0, 8'hE5, 1'b1, 1'b1, 8'hE5},
    '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, pop_i = 0, ser_busy_i = 0, cts_i = 1, clr_i = 0;
  logic [DW-1:0] wr_data_i = '0;
  logic [CW-1:0] trig_lvl_i = 5'd4;
  logic [3:0]    irq_en_i = '0;
  logic [DW-1:0] rd_data_o;
  logic rd_valid_o, ready_o, wr_busy_o, ovf_o, irq_o;
  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  uart_txq_status u_uart_txq_status (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .pop_i, .ser_busy_i, .cts_i,
    .trig_lvl_i, .irq_en_i, .clr_i, .rd_data_o, .rd_valid_o, .ready_o,
    .wr_busy_o, .ovf_o, .irq_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // op: 0 write, 1 pop, 2 idle, 3 clear with write
  task automatic step(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i   = (op == 2'd0) || (op == 2'd3);
    pop_i     = (op == 2'd1);
    clr_i     = (op == 2'd3);
    wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 0; pop_i = 0; clr_i = 0;
  endtask

  task automatic settle();
    @(negedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset ready", ready_o, 1);
    chk("R1 reset valid", rd_valid_o, 0);
    chk("R4 reset busy", wr_busy_o, 0);
    chk("R3 reset ovf", ovf_o, 0);
    chk("R9 reset irq", irq_o, 0);
    @(negedge clk_i); rst_ni = 1;

    for (int i = 0; i < 12; i++) begin
      step(VEC[i].op, VEC[i].data);
      chk(i == 9 ? "R10 valid" : "R2 valid", rd_valid_o, VEC[i].valid);
      chk("R4 busy", wr_busy_o, VEC[i].busy);
      if (VEC[i].valid) chk("R2 head", rd_data_o, VEC[i].head);
    end
    chk("R10 ovf", ovf_o, 0);

    // fill to the limit
    for (int i = 0; i < 16; i++) begin
      step(2'd0, 8'h10 + 8'(i));
      if (i == 14) chk("R1 ready at 15", ready_o, 1);
    end
    chk("R1 ready full", ready_o, 0);
    step(2'd0, 8'hFF);
    chk("R3 ovf set", ovf_o, 1);
    irq_en_i = 4'b0100; settle();
    chk("R9 ovf bit2", irq_o, 1);
    irq_en_i = 4'b0001; settle();
    chk("R6 full above trig", irq_o, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 drain order", rd_data_o, 8'h10 + 8'(i));
      step(2'd1, 8'h00);
    end
    chk("R3 lost word absent", rd_valid_o, 0);
    chk("R3 ovf sticky", ovf_o, 1);
    chk("R6 empty at/below trig", irq_o, 1);

    for (int i = 0; i < 4; i++) step(2'd0, 8'h40 + 8'(i));
    chk("R6 count equals trig", irq_o, 1);
    step(2'd0, 8'h44);
    chk("R6 count above trig", irq_o, 0);

    step(2'd3, 8'h77);
    chk("R8 cleared valid", rd_valid_o, 0);
    chk("R8 cleared ovf", ovf_o, 0);
    chk("R8 ready", ready_o, 1);
    step(2'd2, 8'h00);
    chk("R8 clear write dropped", rd_valid_o, 0);
    chk("R8 no ovf", ovf_o, 0);

    irq_en_i = 4'b0010; ser_busy_i = 1; settle();
    chk("R5 busy shifter", irq_o, 0);
    chk("R4 busy shifter", wr_busy_o, 1);
    ser_busy_i = 0; settle();
    chk("R5 drained", irq_o, 1);
    chk("R4 idle", wr_busy_o, 0);
    step(2'd0, 8'h55);
    chk("R5 queued word", irq_o, 0);
    step(2'd3, 8'h00);

    irq_en_i = 4'b1000;
    @(negedge clk_i); cts_i = 0;
    repeat (2) @(posedge clk_i);
    #1 chk("R7 not yet", irq_o, 0);
    @(posedge clk_i); #1;
    chk("R7 falling change", irq_o, 1);
    repeat (3) @(posedge clk_i); #1;
    chk("R7 sticky", irq_o, 1);
    step(2'd3, 8'h00);
    chk("R7 cleared", irq_o, 0);
    @(negedge clk_i); cts_i = 1;
    repeat (3) @(posedge clk_i); #1;
    chk("R7 rising change", irq_o, 1);
    irq_en_i = 4'b0000; settle();
    chk("R9 masked", irq_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule